// File: doc/BRIEF.md
# Link Self-Test Error Logger

This block watches the receive side of a link self-test run and keeps a compact record of what went wrong. A pattern engine starts a run with a one-cycle start pulse. The logger then waits for the first start delimiter. After that delimiter it checks each valid frame against a per-lane error vector. It counts the frames that carry at least one failing lane. It remembers which lane failed first and reports a two-bit run status.

Two control bits decide how a run ends. The stop-on-error bit ends the run at the first failing frame. The loop-forever bit decides whether the end of a pattern pass ends the run. When a run ends, the logger sends a one-cycle stop request back to the pattern engine. Software can wipe the logged fields with a clear pulse at any time.

Status codes: `00` means running without error, or cleared. `01` means waiting for the first start delimiter. `10` means at least one frame has failed. `11` is never produced. All outputs are registered and change one clock edge after the input that causes them.

Top module: `lst_err_logger`

## Requirements
- R1: After reset, the counter, the lane field and the status read 0, and the stop request is low.
- R2: A start pulse sets status to 01 and zeroes the counter and the lane field on the next edge. Status stays at 01 until a start delimiter is seen.
- R3: The first delimiter strobe of a run moves status from 01 to 00. Status code 11 never appears.
- R4: Once the delimiter is seen, every valid frame with one or more lane bits set adds exactly one to the counter, whatever the number of set bits. The first such frame sets status to 10.
- R5: The 10-bit counter stops at 1023 and never wraps.
- R6: On the first failing frame, the lane field takes the index of the highest set bit of the lane error vector. Bit i of that vector belongs to lane i.
- R7: Later failing frames in the same run leave the lane field unchanged.
- R8: A failing frame is ignored while the delimiter has not been seen, and this includes the cycle in which the delimiter strobe arrives. Counter and lane field keep their values.
- R9: A clear pulse zeroes the counter, the lane field and the status. It wins over a failing frame or a start pulse in the same cycle, and that start pulse is dropped. A clear does not stop a run in progress. After a clear, the next failing frame is again treated as the first one.
- R10: With stop-on-error set, the first failing frame raises the stop request for exactly one cycle and ends the run, so later frames are not counted. With stop-on-error clear, no stop request is raised and counting goes on.
- R11: A pass-done strobe with loop-forever clear raises a one-cycle stop request and ends the run. With loop-forever set, the strobe has no effect.
- R12: While the frame-valid strobe is low, the lane error vector has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a test run |
| sd_seen_i | input | 1 | Start-delimiter-received strobe |
| frame_vld_i | input | 1 | A checked frame is present this cycle |
| lane_err_i | input | LANES (12) | Per-lane error flags for the current frame |
| stop_on_err_i | input | 1 | End the run on the first failing frame |
| loop_forever_i | input | 1 | Ignore end of pattern pass |
| pass_done_i | input | 1 | Pattern engine finished one pass |
| sw_clr_i | input | 1 | Software clear of counter, lane and status |
| err_cnt_o | output | CNT_W (10) | Saturating count of failing frames |
| err_lane_o | output | LANE_W (4) | Lane number of the first failure |
| status_o | output | 2 | Run status code |
| stop_req_o | output | 1 | One-cycle stop request to the pattern engine |

## Verification
The assertions assume that start, clear, delimiter and pass-done are single-cycle strobes sampled at the rising edge. They also assume that all inputs are driven to known values from reset onward. The lane vector is only taken into account while the frame-valid strobe is high. The bench changes every input on the falling edge and holds it for one full cycle, so each strobe is seen at exactly one rising edge. It also drives strobes in the same cycle on purpose (clear with error, delimiter with error, start during a run) to exercise the priority rules while still keeping to these assumptions.

// File: rtl/lst_pkg.sv
package lst_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_WAIT_SD = 2'b01,
    ST_FAIL    = 2'b10
  } lst_status_e;
endpackage

// File: rtl/lst_run_ctrl.sv
module lst_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sd_i,
  input  logic end_ev_i,
  output logic run_o,
  output logic sd_got_o,
  output logic stop_o
);
  logic run_q, sd_q, stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sd_q   <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      stop_q <= end_ev_i & ~start_i;
      if (start_i)       run_q <= 1'b1;
      else if (end_ev_i) run_q <= 1'b0;
      if (start_i)              sd_q <= 1'b0;
      else if (run_q && sd_i)   sd_q <= 1'b1;
    end
  end

  assign run_o    = run_q;
  assign sd_got_o = sd_q;
  assign stop_o   = stop_q;

  AST_STOP_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !run_q); // R10
  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && !start_i |=> !stop_q); // R11
endmodule

// File: rtl/lst_err_track.sv
module lst_err_track #(
  parameter int LANES  = 12,
  parameter int CNT_W  = 10,
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic              err_ev_i,
  input  logic              first_ev_i,
  input  logic [LANES-1:0]  lane_err_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              seen_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [LANE_W-1:0] top_lane(input logic [LANES-1:0] v);
    logic [LANE_W-1:0] r;
    logic hit;
    r   = '0;
    hit = 1'b0;
    for (int i = LANES-1; i >= 0; i--) begin
      if (!hit && v[i]) begin
        r   = LANE_W'(i);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  logic [CNT_W-1:0]  cnt_q;
  logic [LANE_W-1:0] lane_q;
  logic              seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lane_q <= '0;
      seen_q <= 1'b0;
    end else if (clr_i || start_i) begin
      cnt_q  <= '0;
      lane_q <= '0;
      seen_q <= 1'b0;
    end else if (err_ev_i) begin
      cnt_q  <= sat_inc(cnt_q);
      seen_q <= 1'b1;
      if (first_ev_i) lane_q <= top_lane(lane_err_i);
    end
  end

  assign cnt_o  = cnt_q;
  assign lane_o = lane_q;
  assign seen_o = seen_q;

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) && !clr_i && !start_i |=> cnt_q == CNT_MAX); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    err_ev_i && !clr_i && !start_i && (cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R4
  AST_LANE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && !clr_i && !start_i |=> $stable(lane_q)); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0) && (lane_q == '0)); // R9
endmodule

// File: rtl/lst_status.sv
module lst_status
  import lst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        start_i,
  input  logic        sd_ev_i,
  input  logic        first_ev_i,
  output logic [1:0]  status_o
);
  lst_status_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             st_q <= ST_OK;
    else if (clr_i)                         st_q <= ST_OK;
    else if (start_i)                       st_q <= ST_WAIT_SD;
    else if (first_ev_i)                    st_q <= ST_FAIL;
    else if (sd_ev_i && st_q == ST_WAIT_SD) st_q <= ST_OK;
  end

  assign status_o = st_q;

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    status_o != 2'b11); // R3
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_WAIT_SD && !sd_ev_i && !clr_i && !start_i |=> st_q == ST_WAIT_SD); // R2
  AST_START_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !clr_i |=> st_q == ST_WAIT_SD); // R2
endmodule

// File: rtl/lst_err_logger.sv
module lst_err_logger #(
  parameter int LANES  = 12,
  parameter int CNT_W  = 10,
  parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sd_seen_i,
  input  logic              frame_vld_i,
  input  logic [LANES-1:0]  lane_err_i,
  input  logic              stop_on_err_i,
  input  logic              loop_forever_i,
  input  logic              pass_done_i,
  input  logic              sw_clr_i,
  output logic [CNT_W-1:0]  err_cnt_o,
  output logic [LANE_W-1:0] err_lane_o,
  output logic [1:0]        status_o,
  output logic              stop_req_o
);
  logic run_q, sd_got_q, seen_err;
  logic start_eff, ev_err, ev_first, ev_sd, ev_end;

  assign start_eff = start_i & ~sw_clr_i;
  assign ev_err    = run_q & sd_got_q & frame_vld_i & (|lane_err_i);
  assign ev_first  = ev_err & ~seen_err;
  assign ev_sd     = run_q & ~sd_got_q & sd_seen_i;
  assign ev_end    = run_q & ((ev_first & stop_on_err_i) | (pass_done_i & ~loop_forever_i));

  lst_run_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_eff),
    .sd_i     (sd_seen_i),
    .end_ev_i (ev_end),
    .run_o    (run_q),
    .sd_got_o (sd_got_q),
    .stop_o   (stop_req_o)
  );

  lst_err_track #(.LANES(LANES), .CNT_W(CNT_W), .LANE_W(LANE_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (sw_clr_i),
    .start_i    (start_eff),
    .err_ev_i   (ev_err),
    .first_ev_i (ev_first),
    .lane_err_i (lane_err_i),
    .cnt_o      (err_cnt_o),
    .lane_o     (err_lane_o),
    .seen_o     (seen_err)
  );

  lst_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (sw_clr_i),
    .start_i    (start_eff),
    .sd_ev_i    (ev_sd),
    .first_ev_i (ev_first),
    .status_o   (status_o)
  );

  AST_PRE_SD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_got_q && !sw_clr_i && !start_eff |=> $stable(err_cnt_o) && $stable(err_lane_o)); // R8
  AST_NO_VALID_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld_i && !sw_clr_i && !start_eff |=> $stable(err_cnt_o)); // R12
  AST_LOOP_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    loop_forever_i && !stop_on_err_i |=> !stop_req_o); // R11
endmodule

// File: tb/lst_err_logger_tb.sv
module lst_err_logger_tb_top;
  localparam int LANES = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, sd_seen_i = 0, frame_vld_i = 0;
  logic [LANES-1:0] lane_err_i = '0;
  logic stop_on_err_i = 0, loop_forever_i = 0, pass_done_i = 0, sw_clr_i = 0;
  logic [9:0] err_cnt_o;
  logic [3:0] err_lane_o;
  logic [1:0] status_o;
  logic stop_req_o;

  always #2.5 clk = ~clk;

  lst_err_logger dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sd_seen_i(sd_seen_i),
    .frame_vld_i(frame_vld_i), .lane_err_i(lane_err_i),
    .stop_on_err_i(stop_on_err_i), .loop_forever_i(loop_forever_i),
    .pass_done_i(pass_done_i), .sw_clr_i(sw_clr_i),
    .err_cnt_o(err_cnt_o), .err_lane_o(err_lane_o),
    .status_o(status_o), .stop_req_o(stop_req_o)
  );

  typedef struct {
    int    cnt;
    int    lane;
    int    st;
    bit    stp;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  bit m_run = 0, m_sd = 0, m_seen = 0;
  int m_cnt = 0, m_lane = 0, m_st = 0;
  bit m_stp = 0;

  task automatic step(input bit st, input bit sd, input bit fv,
                      input logic [LANES-1:0] le, input bit soe, input bit lp,
                      input bit pd, input bit clr, input string tag);
    bit s_eff, err, first, endr;
    int hi;
    exp_t e;
    @(negedge clk);
    start_i = st; sd_seen_i = sd; frame_vld_i = fv; lane_err_i = le;
    stop_on_err_i = soe; loop_forever_i = lp; pass_done_i = pd; sw_clr_i = clr;
    s_eff = st && !clr;
    err   = m_run && m_sd && fv && (le != 0);
    first = err && !m_seen;
    endr  = m_run && ((first && soe) || (pd && !lp));
    hi = 0;
    for (int i = 0; i < LANES; i++) if (le[i]) hi = i;
    m_stp = endr && !s_eff;
    if (clr) m_st = 0;
    else if (s_eff) m_st = 1;
    else if (first) m_st = 2;
    else if (m_run && !m_sd && sd && m_st == 1) m_st = 0;
    if (clr || s_eff) begin
      m_cnt = 0; m_lane = 0; m_seen = 0;
    end else if (err) begin
      if (m_cnt < 1023) m_cnt++;
      if (!m_seen) m_lane = hi;
      m_seen = 1;
    end
    if (s_eff) m_sd = 0;
    else if (m_run && sd) m_sd = 1;
    if (s_eff) m_run = 1;
    else if (endr) m_run = 0;
    e.cnt = m_cnt; e.lane = m_lane; e.st = m_st; e.stp = m_stp; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n, input bit soe, input bit lp, input string tag);
    for (int k = 0; k < n; k++) step(0, 0, 0, '0, soe, lp, 0, 0, tag);
  endtask

  // monitor: compares one expected item per cycle after the edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (err_cnt_o !== 10'(e.cnt) || err_lane_o !== 4'(e.lane) ||
          status_o !== 2'(e.st) || stop_req_o !== e.stp) begin
        bad++;
        $display("FAIL %s: cnt=%0d lane=%0d st=%0d stop=%0b expected cnt=%0d lane=%0d st=%0d stop=%0b",
                 e.tag, err_cnt_o, err_lane_o, status_o, stop_req_o,
                 e.cnt, e.lane, e.st, e.stp);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (err_cnt_o !== 0 || err_lane_o !== 0 || status_o !== 0 || stop_req_o !== 0) begin
      bad++;
      $display("FAIL R1: cnt=%0d lane=%0d st=%0d stop=%0b expected all zero",
               err_cnt_o, err_lane_o, status_o, stop_req_o);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(2, 0, 0, "R1 idle after reset");

    // run 1: counting, lane capture, pre-delimiter ignore
    step(1, 0, 0, '0, 0, 0, 0, 0, "R2 start");
    idle(3, 0, 0, "R2 waiting for delimiter");
    step(0, 0, 1, 12'h0F0, 0, 0, 0, 0, "R8 error before delimiter");
    step(0, 1, 1, 12'h801, 0, 0, 0, 0, "R8 error with delimiter");
    step(0, 0, 0, '0, 0, 0, 0, 0, "R3 delimiter seen");
    step(0, 0, 0, 12'hFFF, 0, 0, 0, 0, "R12 vector without valid");
    step(0, 0, 1, 12'h02C, 0, 0, 0, 0, "R6 first error top lane 5");
    step(0, 0, 1, 12'h200, 0, 0, 0, 0, "R7 later error lane 9");
    step(0, 0, 1, 12'hFFF, 0, 0, 0, 0, "R4 one count per frame");
    step(0, 1, 1, 12'h001, 0, 0, 0, 0, "R10 no stop when disabled");
    step(0, 0, 1, 12'h400, 0, 0, 0, 1, "R9 clear wins over error");
    step(0, 0, 1, 12'h008, 0, 0, 0, 0, "R9 first error again after clear");
    step(0, 0, 1, 12'h800, 0, 0, 0, 0, "R7 lane held");
    step(1, 0, 0, '0, 0, 0, 0, 1, "R9 clear drops start");
    step(0, 0, 0, '0, 0, 0, 1, 0, "R11 pass end without loop");
    idle(2, 0, 0, "R11 run ended");
    step(0, 1, 1, 12'h010, 0, 0, 0, 0, "R11 no counting after end");

    // run 2: stop on error
    step(1, 0, 0, '0, 1, 0, 0, 0, "R2 start run 2");
    step(0, 1, 0, '0, 1, 0, 0, 0, "R3 delimiter run 2");
    step(0, 0, 1, 12'h006, 1, 0, 0, 0, "R10 first error stops");
    step(0, 0, 1, 12'h001, 1, 0, 0, 0, "R10 stop pulse");
    step(0, 0, 1, 12'h001, 1, 0, 0, 0, "R10 not counted after stop");
    idle(2, 1, 0, "R10 stop is one cycle");

    // run 3: loop forever ignores pass end
    step(1, 0, 0, '0, 0, 1, 0, 0, "R2 start run 3");
    step(0, 1, 0, '0, 0, 1, 0, 0, "R3 delimiter run 3");
    step(0, 0, 0, '0, 0, 1, 1, 0, "R11 loop ignores pass end");
    step(0, 0, 1, 12'h100, 0, 1, 0, 0, "R11 still counting in loop");
    step(0, 0, 0, '0, 0, 1, 1, 0, "R11 second pass end ignored");
    for (int k = 0; k < 1030; k++) step(0, 0, 1, 12'h003, 0, 1, 0, 0, "R5 saturation");
    step(0, 0, 1, 12'h003, 0, 1, 0, 0, "R5 held at max");
    step(0, 0, 0, '0, 0, 1, 0, 1, "R9 clear at max");
    step(1, 0, 0, '0, 0, 1, 0, 0, "R2 restart during run");
    idle(3, 0, 1, "R2 waits again");
    idle(2, 0, 0, "drain");
    wait (sb_q.size() == 0);
    @(posedge clk); #2;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule